// File: doc/BRIEF.md
# Shift-and-Add Multiply Step Unit

This block carries out one iteration of a signed shift-and-add multiplication per enabled clock. The caller feeds back the partial product, the multiplier register and the sign and overflow flags that the previous step produced. Each step shifts the partial product right by one bit and adds the multiplicand when the current multiplier bit is set. The bit that leaves the partial product enters the top of the multiplier register. With the flags cleared, the partial product zeroed and the multiplier loaded, W steps followed by one step with a zero addend leave the low product word in the multiplier register and the high word in the destination. A final subtraction of the multiplicand from the high word, done only when the multiplier is negative, gives the full signed product.

The top bit of the shifted partial product is not filled with zero. It takes the exclusive OR of the incoming sign and overflow flags, which is the true sign of the previous sum. This lets the partial product behave as a signed value even when the previous addition overflowed. Every result is computed from the inputs as they stood at the start of the step. The results are registered together on one clock enable.

Top module: `mulstep_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first enabled step, the destination, multiplier register and all four flags read zero.
- R2: The shifted operand is the first operand shifted right by one bit, with bit W-1 equal to flag_n XOR flag_v.
- R3: The addend is the second operand when bit 0 of y_in is 1. It is zero when that bit is 0, in which case the destination equals the shifted operand and the carry and overflow flags are 0.
- R4: The destination is the sum of the shifted operand and the addend, modulo 2^W.
- R5: The sign flag equals bit W-1 of the destination, and the zero flag is 1 exactly when the destination is zero.
- R6: The carry flag is the carry out of bit W-1 of the unsigned addition with no carry in. The overflow flag is 1 when both addends have the same bit W-1 and the sum's bit W-1 differs from it.
- R7: The new multiplier register value is y_in shifted right by one bit, with bit W-1 equal to bit 0 of the original first operand.
- R8: With en low, every output keeps its value, whatever the other inputs do.
- R9: All outputs change on the clock edge where en is sampled high and are visible after that edge, one cycle after the inputs are applied.
- R10: Starting from a zero partial product, cleared flags and the multiplier in y_in, W steps with the multiplicand as second operand and then one step with a zero second operand give the following result. Taken as {destination minus (multiplicand if the multiplier is negative), multiplier register}, it equals the 2W-bit signed product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Step enable; outputs load on an edge where it is high |
| opa | input | W | Partial product input (first operand) |
| opb | input | W | Multiplicand input (second operand) |
| y_in | input | W | Multiplier register input |
| flag_n | input | 1 | Incoming sign flag |
| flag_v | input | 1 | Incoming overflow flag |
| rd_q | output | W | Registered destination value |
| y_q | output | W | Registered new multiplier register value |
| n_q | output | 1 | Registered sign flag |
| z_q | output | 1 | Registered zero flag |
| v_q | output | 1 | Registered overflow flag |
| c_q | output | 1 | Registered carry flag |

## Verification
The hardest case is a step whose incoming overflow flag is set, because the fold of N XOR V then changes the partial product's sign. A wrong fold only shows up as a wrong product many steps later. The stimulus reaches this case by running complete products with extreme operands, such as the most negative value times itself, and by sweeping every operand pair of a 4-bit instance. In those sweeps the partial sums overflow regularly. Single directed steps also drive each flag pair, the zero-addend path and wraparound to zero directly.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } mstep_flags_t;

   localparam mstep_flags_t MSTEP_FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/mstep_prep.sv
module mstep_prep #(
   parameter int W = 32
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic [W-1:0] y_in,
   input  logic         sign_fold,
   output logic [W-1:0] shifted,
   output logic [W-1:0] addend,
   output logic [W-1:0] y_next
);
   localparam int TOP = W - 1;

   always_comb begin
      shifted = {sign_fold, opa[TOP:1]};
      addend  = y_in[0] ? opb : '0;
      y_next  = {opa[0], y_in[TOP:1]};
   end

endmodule

// File: rtl/mstep_adder.sv
module mstep_adder
   import mstep_pkg::*;
#(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [W-1:0]  sum,
   output mstep_flags_t  flags
);
   localparam int TOP = W - 1;

   logic carry_out;
   logic ovf;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign carry_out = cy[W];
         assign ovf       = cy[W] ^ cy[TOP];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide      = {1'b0, a} + {1'b0, b};
         assign sum       = wide[TOP:0];
         assign carry_out = wide[W];
         assign ovf       = (a[TOP] == b[TOP]) && (wide[TOP] != a[TOP]);
      end
   endgenerate

   always_comb begin
      flags.n = sum[TOP];
      flags.z = (sum == '0);
      flags.v = ovf;
      flags.c = carry_out;
   end

endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
   import mstep_pkg::*;
#(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic [W-1:0] y_in,
   input  logic         flag_n,
   input  logic         flag_v,
   output logic [W-1:0] rd_q,
   output logic [W-1:0] y_q,
   output logic         n_q,
   output logic         z_q,
   output logic         v_q,
   output logic         c_q
);
   localparam int TOP = W - 1;

   initial begin
      assert (W >= 2) else $error("mulstep_unit: W must be at least 2");
   end

   logic [W-1:0] shifted;
   logic [W-1:0] addend;
   logic [W-1:0] y_next;
   logic [W-1:0] sum;
   mstep_flags_t flags_next;
   mstep_flags_t flags_q;

   mstep_prep #(.W(W)) u_prep (
      .opa       (opa),
      .opb       (opb),
      .y_in      (y_in),
      .sign_fold (flag_n ^ flag_v),
      .shifted   (shifted),
      .addend    (addend),
      .y_next    (y_next)
   );

   mstep_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a     (shifted),
      .b     (addend),
      .sum   (sum),
      .flags (flags_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         y_q     <= '0;
         flags_q <= MSTEP_FLAGS_CLEAR;
      end else if (en) begin
         rd_q    <= sum;
         y_q     <= y_next;
         flags_q <= flags_next;
      end
   end

   assign n_q = flags_q.n;
   assign z_q = flags_q.z;
   assign v_q = flags_q.v;
   assign c_q = flags_q.c;

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(rd_q) && $stable(y_q) && $stable(flags_q))) else $error("hold"); // R8

   AST_Y_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (y_q[TOP] == $past(opa[0]))) else $error("y top"); // R7

   AST_Y_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (y_q[TOP-1:0] == $past(y_in[TOP:1]))) else $error("y shift"); // R7

   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (n_q == rd_q[TOP])) else $error("sign flag"); // R5

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (z_q == (rd_q == '0))) else $error("zero flag"); // R5

   AST_ADDEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !y_in[0]) |=> ((rd_q == {$past(flag_n ^ flag_v), $past(opa[TOP:1])}) && !c_q && !v_q))
      else $error("zero addend"); // R3

endmodule

// File: tb/mulstep_unit_tb.sv
module mulstep_unit_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // wide instance (behavioural adder)
   logic        en;
   logic [31:0] opa, opb, y_in;
   logic        fn, fv;
   logic [31:0] rd_q, y_q;
   logic        n_q, z_q, v_q, c_q;

   mulstep_unit #(.W(32), .RIPPLE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .opa(opa), .opb(opb), .y_in(y_in),
      .flag_n(fn), .flag_v(fv), .rd_q(rd_q), .y_q(y_q),
      .n_q(n_q), .z_q(z_q), .v_q(v_q), .c_q(c_q));

   // narrow instance (ripple adder) for exhaustive sweeps
   logic       s_en;
   logic [3:0] s_opa, s_opb, s_y;
   logic       s_fn, s_fv;
   logic [3:0] s_rd, s_yq;
   logic       s_n, s_z, s_v, s_c;

   mulstep_unit #(.W(4), .RIPPLE(1'b1)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .en(s_en), .opa(s_opa), .opb(s_opb), .y_in(s_y),
      .flag_n(s_fn), .flag_v(s_fv), .rd_q(s_rd), .y_q(s_yq),
      .n_q(s_n), .z_q(s_z), .v_q(s_v), .c_q(s_c));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one step on the wide instance, expected values from the requirements
   task automatic one_step(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] y, input logic n, input logic v);
      logic [31:0] sh, ad, r, ye;
      logic [32:0] s;
      logic [3:0]  fe;
      sh = {n ^ v, a[31:1]};                 // R2
      ad = y[0] ? b : 32'h0;                 // R3
      s  = {1'b0, sh} + {1'b0, ad};          // R4
      r  = s[31:0];
      ye = {a[0], y[31:1]};                  // R7
      fe = {r[31], r == 32'h0, (sh[31] == ad[31]) && (r[31] != sh[31]), s[32]}; // R5 R6
      opa = a; opb = b; y_in = y; fn = n; fv = v; en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check({req, " dest"}, 64'(rd_q), 64'(r));
      check({req, " y"}, 64'(y_q), 64'(ye));
      check({req, " flags"}, 64'({n_q, z_q, v_q, c_q}), 64'(fe));
   endtask

   task automatic mul32(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] hi;
      logic [63:0] got, exp;
      opa = 32'h0; opb = a; y_in = b; fn = 1'b0; fv = 1'b0; en = 1'b1;
      for (int k = 0; k < 33; k++) begin
         if (k == 32) opb = 32'h0;
         @(negedge clk);
         opa = rd_q; y_in = y_q; fn = n_q; fv = v_q;
      end
      en  = 1'b0;
      hi  = rd_q - (b[31] ? a : 32'h0);
      got = {hi, y_q};
      exp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
      check("R10 product32", got, exp);
   endtask

   task automatic mul4(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] hi;
      logic [7:0] got, exp;
      s_opa = 4'h0; s_opb = a; s_y = b; s_fn = 1'b0; s_fv = 1'b0; s_en = 1'b1;
      for (int k = 0; k < 5; k++) begin
         if (k == 4) s_opb = 4'h0;
         @(negedge clk);
         s_opa = s_rd; s_y = s_yq; s_fn = s_n; s_fv = s_v;
      end
      s_en = 1'b0;
      hi  = s_rd - (b[3] ? a : 4'h0);
      got = {hi, s_yq};
      exp = $signed({{4{a[3]}}, a}) * $signed({{4{b[3]}}, b});
      check("R10 product4", 64'(got), 64'(exp));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      en = 1'b0; opa = '0; opb = '0; y_in = '0; fn = 1'b0; fv = 1'b0;
      s_en = 1'b0; s_opa = '0; s_opb = '0; s_y = '0; s_fn = 1'b0; s_fv = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 64'({rd_q, n_q, z_q, v_q, c_q}), 64'h0);
      check("R1 reset y", 64'(y_q), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 64'({rd_q, y_q}), 64'h0);

      // R9: inputs applied, no output change until the enabled edge
      opa = 32'h8000_0003; opb = 32'h1; y_in = 32'h1; fn = 1'b0; fv = 1'b0;
      #1 check("R9 no change before edge", 64'(rd_q), 64'h0);

      one_step("R2 fold n^v=1 (n=1,v=0)", 32'h0000_0006, 32'h0, 32'h0, 1'b1, 1'b0);
      one_step("R2 fold n^v=0 (n=1,v=1)", 32'hFFFF_FFFE, 32'h0, 32'h2, 1'b1, 1'b1);
      one_step("R2 fold n^v=1 (n=0,v=1)", 32'h0000_0001, 32'h0, 32'h8000_0000, 1'b0, 1'b1);
      one_step("R3 addend ignored", 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0);
      one_step("R4 plain add", 32'h0000_0100, 32'h0000_0055, 32'h1, 1'b0, 1'b0);
      one_step("R5 wrap to zero", 32'hFFFF_FFFF, 32'h0000_0001, 32'h1, 1'b1, 1'b0);
      one_step("R6 carry out", 32'hF000_0000, 32'hC000_0000, 32'h3, 1'b1, 1'b0);
      one_step("R6 positive overflow", 32'hFFFF_FFFE, 32'h4000_0000, 32'h1, 1'b0, 1'b0);
      one_step("R6 negative overflow", 32'h0, 32'h8000_0000, 32'h1, 1'b0, 1'b1);
      one_step("R7 low bit into y", 32'h0000_0001, 32'h0, 32'hAAAA_AAAB, 1'b0, 1'b0);

      // R8: en low, inputs change, outputs hold
      begin
         logic [31:0] rd_hold, y_hold;
         logic [3:0]  f_hold;
         rd_hold = rd_q; y_hold = y_q; f_hold = {n_q, z_q, v_q, c_q};
         en = 1'b0; opa = 32'h5555_5555; opb = 32'h7777_7777; y_in = 32'hFFFF_FFFF; fn = 1'b1;
         repeat (3) @(negedge clk);
         check("R8 hold dest", 64'(rd_q), 64'(rd_hold));
         check("R8 hold y", 64'(y_q), 64'(y_hold));
         check("R8 hold flags", 64'({n_q, z_q, v_q, c_q}), 64'(f_hold));
      end

      mul32(32'h0, 32'h0);
      mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      mul32(32'h8000_0000, 32'h8000_0000);
      mul32(32'h8000_0000, 32'hFFFF_FFFF);
      mul32(32'h7FFF_FFFF, 32'h7FFF_FFFF);
      mul32(32'h8000_0000, 32'h7FFF_FFFF);
      mul32(32'h0000_0001, 32'hFFFF_FFFF);
      for (int i = 0; i < 400; i++) mul32($urandom, $urandom);

      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            mul4(4'(a), 4'(b));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule